// File: doc/BRIEF.md
# Two-Tier Sum-of-Products Logic Array

This block is a configurable sum-of-products plane. Each output sum draws on two tiers of product terms. The first tier gives every output a private group of five product terms that feed no other output. The second tier is a pool of 32 product terms that all outputs share. A fully programmable OR plane chooses, for each output, which pool terms join its sum. One pool term can be selected on many outputs at once, so logic that several sums have in common is built only once. The largest sum on one output uses all 37 terms: its five private terms and the whole pool.

The input is a vector of signals from the interconnect. The block expands each signal into a true literal and a complement literal. Every product term has an AND mask over these literals. The sums are purely combinational from the inputs and the stored configuration, and they feed a downstream register stage. A parallel write port loads the configuration. Each write is addressed either to one product term's AND mask or to one output's OR-select word.

Top module: `pla_array`

## Requirements
- R1: Literal index 2*i is input i in true form, and literal index 2*i+1 is input i complemented. A product term is 1 exactly when every literal set in its mask is 1. A mask that selects both forms of one input therefore never fires.
- R2: A product term whose mask selects no literal evaluates to 0.
- R3: Each output has five private product terms. The private term k of output o is written with cfg_kind=0 at address o*5+k, and it contributes only to output o.
- R4: The shared pool holds 32 product terms, written with cfg_kind=1 at addresses 0..31. Bit j of output o's OR-select word, written with cfg_kind=2 at address o from cfg_data[31:0], puts pool term j into sum o.
- R5: A single pool term selected in several OR-select words drives all of those outputs at the same time.
- R6: Each output is the OR of its five private terms and every selected pool term, up to 37 terms. Any one of those terms firing alone sets the output.
- R7: A write with cfg_we=1 takes effect at the rising clock edge that samples it. After that edge the outputs follow the inputs combinationally under the new configuration.
- R8: A write to an address at or beyond the range of its kind has no effect on any output. So does any write with cfg_kind=3.
- R9: A synchronous active-low reset clears every mask and every OR-select word, so every output reads 0 for any input.
- R10: While no write is made and the inputs do not change, the outputs do not change.
- R11: A write to a private term or to an OR-select word can change only the output that owns it.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for configuration writes |
| rst_n | input | 1 | Synchronous active-low reset; clears all configuration |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_kind | input | 2 | Write target: 0 private-term mask, 1 pool-term mask, 2 OR-select word, 3 reserved |
| cfg_addr | input | AW (7) | Term index or output index for the write |
| cfg_data | input | DW (72) | Mask bits (low 2*N_IN) or OR-select bits (low N_POOL) |
| lit_in | input | N_IN (36) | Input signals from the interconnect |
| sum_out | output | N_OUT (16) | One sum-of-products result per output |

## Verification
A wrong stored mask, or an OR-select bit that is set or lost, appears on the affected sum only when the input pattern makes the faulty term matter. The bench therefore drives one-hot patterns that make each term decide an output alone. It also drives complement patterns and a long pseudo-random run. A write that lands at the wrong address shows up on a different output at the first input sample after the write's clock edge. The ignored-write cases use addresses chosen so that any aliasing would light a visible output. The reset check confirms that no configuration survives a reset.

// File: rtl/pla_pkg.sv
// Shared definitions for the two-tier product-term array.
// Assumes: the write kind is a two-bit code, and code 3 is reserved.
package pla_pkg;
    typedef enum logic [1:0] {
        CFG_DED   = 2'd0,
        CFG_POOL  = 2'd1,
        CFG_ORSEL = 2'd2,
        CFG_RSVD  = 2'd3
    } cfg_kind_e;
endpackage

// File: rtl/pt_term.sv
// One product term: the AND of the literals its mask selects.
// Assumes: an empty mask must evaluate to 0 rather than 1.
module pt_term #(
    parameter int LIT_W = 72
) (
    input  logic [LIT_W-1:0] lits,
    input  logic [LIT_W-1:0] mask,
    output logic             hit
);
    // Fire only when the mask is non-empty and every selected literal is high.
    always_comb begin
        hit = (|mask) && ((lits & mask) == mask);
    end
endmodule

// File: rtl/pt_cfg_regs.sv
// Configuration store: the private-term masks, the pool-term masks and the
// OR-select words.
// Assumes: one write per cycle; an address beyond its kind's range is dropped.
module pt_cfg_regs
    import pla_pkg::*;
#(
    parameter int N_OUT  = 16,
    parameter int N_DED  = 5,
    parameter int N_POOL = 32,
    parameter int LIT_W  = 72,
    parameter int AW     = 7,
    parameter int DW     = 72,
    localparam int N_DT  = N_OUT * N_DED
) (
    input  logic                             clk,
    input  logic                             rst_n,
    input  logic                             we,
    input  cfg_kind_e                        kind,
    input  logic [AW-1:0]                    addr,
    input  logic [DW-1:0]                    data,
    output logic [N_DT-1:0][LIT_W-1:0]       ded_mask,
    output logic [N_POOL-1:0][LIT_W-1:0]     pool_mask,
    output logic [N_OUT-1:0][N_POOL-1:0]     or_sel
);
    generate
        for (genvar d = 0; d < N_DT; d++) begin : g_ded
            // Load private-term mask d on an addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    ded_mask[d] <= '0;
                else if (we && kind == CFG_DED && addr == AW'(d))
                    ded_mask[d] <= data[LIT_W-1:0];
            end
        end
        for (genvar p = 0; p < N_POOL; p++) begin : g_pool
            // Load pool-term mask p on an addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    pool_mask[p] <= '0;
                else if (we && kind == CFG_POOL && addr == AW'(p))
                    pool_mask[p] <= data[LIT_W-1:0];
            end
        end
        for (genvar o = 0; o < N_OUT; o++) begin : g_or
            // Load the OR-select word of output o on an addressed write.
            always_ff @(posedge clk) begin
                if (!rst_n)
                    or_sel[o] <= '0;
                else if (we && kind == CFG_ORSEL && addr == AW'(o))
                    or_sel[o] <= data[N_POOL-1:0];
            end
        end
    endgenerate
endmodule

// File: rtl/pt_or_plane.sv
// OR plane: merges each output's private terms with the pool terms it selects.
// Assumes: private terms are grouped by output, N_DED terms per output.
module pt_or_plane #(
    parameter int N_OUT  = 16,
    parameter int N_DED  = 5,
    parameter int N_POOL = 32,
    localparam int N_DT  = N_OUT * N_DED
) (
    input  logic [N_DT-1:0]              ded_hit,
    input  logic [N_POOL-1:0]            pool_hit,
    input  logic [N_OUT-1:0][N_POOL-1:0] or_sel,
    output logic [N_OUT-1:0]             sums
);
    // Build every output sum from its own terms and the selected pool terms.
    always_comb begin
        for (int o = 0; o < N_OUT; o++) begin
            sums[o] = (|ded_hit[o*N_DED +: N_DED]) | (|(pool_hit & or_sel[o]));
        end
    end
endmodule

// File: rtl/pla_array.sv
// Top of the two-tier array: literal expansion, the product terms, the
// configuration store and the OR plane.
// Assumes: the sums are consumed combinationally; only the configuration is
// registered.
module pla_array
    import pla_pkg::*;
#(
    parameter int N_IN   = 36,
    parameter int N_OUT  = 16,
    parameter int N_DED  = 5,
    parameter int N_POOL = 32,
    localparam int LIT_W  = 2 * N_IN,
    localparam int N_DT   = N_OUT * N_DED,
    localparam int SPAN_A = (N_DT > N_POOL) ? N_DT : N_POOL,
    localparam int SPAN   = (SPAN_A > N_OUT) ? SPAN_A : N_OUT,
    localparam int AW     = (SPAN > 1) ? $clog2(SPAN) : 1,
    localparam int DW     = (LIT_W > N_POOL) ? LIT_W : N_POOL
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_kind,
    input  logic [AW-1:0]    cfg_addr,
    input  logic [DW-1:0]    cfg_data,
    input  logic [N_IN-1:0]  lit_in,
    output logic [N_OUT-1:0] sum_out
);
    logic [LIT_W-1:0]                lits;
    logic [N_DT-1:0][LIT_W-1:0]      ded_mask;
    logic [N_POOL-1:0][LIT_W-1:0]    pool_mask;
    logic [N_OUT-1:0][N_POOL-1:0]    or_sel;
    logic [N_DT-1:0]                 ded_hit;
    logic [N_POOL-1:0]               pool_hit;
    cfg_kind_e                       kind;

    // Map the raw write code onto the kind enum.
    always_comb begin
        kind = cfg_kind_e'(cfg_kind);
    end

    generate
        for (genvar i = 0; i < N_IN; i++) begin : g_lit
            // Even literal is the true form, odd literal the complement.
            always_comb begin
                lits[2*i]   = lit_in[i];
                lits[2*i+1] = ~lit_in[i];
            end
        end
    endgenerate

    pt_cfg_regs #(
        .N_OUT(N_OUT), .N_DED(N_DED), .N_POOL(N_POOL),
        .LIT_W(LIT_W), .AW(AW), .DW(DW)
    ) i_cfg (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .kind(kind),
        .addr(cfg_addr), .data(cfg_data),
        .ded_mask(ded_mask), .pool_mask(pool_mask), .or_sel(or_sel)
    );

    generate
        for (genvar d = 0; d < N_DT; d++) begin : g_dterm
            pt_term #(.LIT_W(LIT_W)) i_term (
                .lits(lits), .mask(ded_mask[d]), .hit(ded_hit[d])
            );
        end
        for (genvar p = 0; p < N_POOL; p++) begin : g_pterm
            pt_term #(.LIT_W(LIT_W)) i_term (
                .lits(lits), .mask(pool_mask[p]), .hit(pool_hit[p])
            );
        end
    endgenerate

    pt_or_plane #(
        .N_OUT(N_OUT), .N_DED(N_DED), .N_POOL(N_POOL)
    ) i_or (
        .ded_hit(ded_hit), .pool_hit(pool_hit), .or_sel(or_sel), .sums(sum_out)
    );
endmodule

// File: rtl/pla_array_chk.sv
// Checker for pla_array: relates writes and input changes to output changes.
// Assumes: it is bound to every instance of pla_array.
module pla_array_chk
    import pla_pkg::*;
#(
    parameter int N_IN   = 36,
    parameter int N_OUT  = 16,
    parameter int N_DED  = 5,
    parameter int N_POOL = 32,
    parameter int AW     = 7
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_we,
    input logic [1:0]       cfg_kind,
    input logic [AW-1:0]    cfg_addr,
    input logic [N_IN-1:0]  lit_in,
    input logic [N_OUT-1:0] sum_out
);
    localparam int N_DT = N_OUT * N_DED;

    logic [N_OUT-1:0] allow_c, allow_q;
    logic             valid_c, valid_q, we_q, live_q;

    // Work out which outputs the current write may legally affect.
    always_comb begin
        allow_c = '0;
        valid_c = 1'b0;
        case (cfg_kind_e'(cfg_kind))
            CFG_DED: if (int'(cfg_addr) < N_DT) begin
                valid_c = 1'b1;
                allow_c[int'(cfg_addr) / N_DED] = 1'b1;
            end
            CFG_POOL: if (int'(cfg_addr) < N_POOL) begin
                valid_c = 1'b1;
                allow_c = '1;
            end
            CFG_ORSEL: if (int'(cfg_addr) < N_OUT) begin
                valid_c = 1'b1;
                allow_c[int'(cfg_addr)] = 1'b1;
            end
            default: ;
        endcase
    end

    // Keep one cycle of write history next to a post-reset marker.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            allow_q <= '0;
            valid_q <= 1'b0;
            we_q    <= 1'b0;
            live_q  <= 1'b0;
        end else begin
            allow_q <= allow_c;
            valid_q <= valid_c;
            we_q    <= cfg_we;
            live_q  <= 1'b1;
        end
    end

    // R9
    reset_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (sum_out == '0));

    // R10
    quiet_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && !we_q && $stable(lit_in)) |-> $stable(sum_out));

    // R11
    write_scope_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && we_q && $stable(lit_in)) |->
            (((sum_out ^ $past(sum_out)) & ~allow_q) == '0));

    // R8
    ignored_write_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (live_q && we_q && !valid_q && $stable(lit_in)) |-> $stable(sum_out));
endmodule

bind pla_array pla_array_chk #(
    .N_IN(N_IN), .N_OUT(N_OUT), .N_DED(N_DED), .N_POOL(N_POOL), .AW(AW)
) i_pla_array_chk (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
    .cfg_addr(cfg_addr), .lit_in(lit_in), .sum_out(sum_out)
);

// File: tb/test_pla_array.sv
// Scoreboard bench for pla_array. A driver pushes expected sums taken from a
// behavioural model. A monitor pops them and compares them with the outputs.
module test_pla_array;
    localparam int N_IN   = 36;
    localparam int N_OUT  = 16;
    localparam int N_DED  = 5;
    localparam int N_POOL = 32;
    localparam int LIT_W  = 2 * N_IN;
    localparam int N_DT   = N_OUT * N_DED;
    localparam int AW     = 7;
    localparam int DW     = 72;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic             cfg_we = 1'b0;
    logic [1:0]       cfg_kind = '0;
    logic [AW-1:0]    cfg_addr = '0;
    logic [DW-1:0]    cfg_data = '0;
    logic [N_IN-1:0]  xin = '0;
    logic [N_OUT-1:0] sum_out;

    int n_chk = 0;
    int n_err = 0;
    bit finished = 0;

    logic [LIT_W-1:0]  m_ded  [N_DT];
    logic [LIT_W-1:0]  m_pool [N_POOL];
    logic [N_POOL-1:0] m_or   [N_OUT];

    logic [N_OUT-1:0] exp_q[$];
    string            tag_q[$];
    event             chk_ev;

    pla_array i_pla_array (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_kind(cfg_kind),
        .cfg_addr(cfg_addr), .cfg_data(cfg_data), .lit_in(xin), .sum_out(sum_out)
    );

    always #10 clk = ~clk;

    // Reference term: each literal is checked on its own against the input.
    function automatic bit model_term(input logic [LIT_W-1:0] m, input logic [N_IN-1:0] x);
        if (m == '0) return 1'b0;
        for (int i = 0; i < N_IN; i++) begin
            if (m[2*i] && !x[i]) return 1'b0;
            if (m[2*i+1] && x[i]) return 1'b0;
        end
        return 1'b1;
    endfunction

    function automatic logic [N_OUT-1:0] model_y(input logic [N_IN-1:0] x);
        logic [N_OUT-1:0] y = '0;
        for (int o = 0; o < N_OUT; o++) begin
            for (int k = 0; k < N_DED; k++)
                if (model_term(m_ded[o*N_DED+k], x)) y[o] = 1'b1;
            for (int j = 0; j < N_POOL; j++)
                if (m_or[o][j] && model_term(m_pool[j], x)) y[o] = 1'b1;
        end
        return y;
    endfunction

    task automatic model_clear();
        for (int d = 0; d < N_DT; d++) m_ded[d] = '0;
        for (int p = 0; p < N_POOL; p++) m_pool[p] = '0;
        for (int o = 0; o < N_OUT; o++) m_or[o] = '0;
    endtask

    task automatic expect_now(input string tag);
        #1;
        exp_q.push_back(model_y(xin));
        tag_q.push_back(tag);
        -> chk_ev;
        #1;
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst_n = 1'b0;
        repeat (3) @(posedge clk);
        model_clear();
        @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic wr(input logic [1:0] k, input int a, input logic [DW-1:0] d);
        @(negedge clk);
        cfg_we = 1'b1; cfg_kind = k; cfg_addr = AW'(a); cfg_data = d;
        @(posedge clk);
        #1;
        cfg_we = 1'b0;
        if (k == 2'd0 && a < N_DT)   m_ded[a]  = d[LIT_W-1:0];
        if (k == 2'd1 && a < N_POOL) m_pool[a] = d[LIT_W-1:0];
        if (k == 2'd2 && a < N_OUT)  m_or[a]   = d[N_POOL-1:0];
    endtask

    task automatic set_x(input logic [N_IN-1:0] v, input string tag);
        @(negedge clk);
        xin = v;
        expect_now(tag);
    endtask

    function automatic logic [DW-1:0] lit_bit(input int idx);
        return DW'(1) << idx;
    endfunction

    // Monitor: pop every expected item and compare it with the outputs.
    initial begin
        forever begin
            @(chk_ev);
            while (exp_q.size() > 0) begin
                logic [N_OUT-1:0] e;
                string t;
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                n_chk++;
                if (sum_out !== e) begin
                    n_err++;
                    $display("FAIL %s: sum_out=%h expected %h", t, sum_out, e);
                end
            end
        end
    end

    // Watchdog.
    initial begin
        #(20 * 150000);
        if (!finished) begin
            finished = 1;
            n_err++;
            n_chk++;
            $display("FAIL watchdog: run did not finish");
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end

    // Driver.
    initial begin
        logic [N_IN-1:0] lfsr;
        model_clear();
        do_reset();
        // R9 R2: everything is cleared; empty masks give 0.
        set_x('0, "R9 reset zero x=0");
        set_x('1, "R9 R2 reset zero x=ones");

        // R3 R1 R7: private term 2 of output 3 = x0 & ~x1.
        wr(2'd0, 3*N_DED + 2, lit_bit(0) | lit_bit(3));
        expect_now("R7 write visible after edge");
        set_x(36'h1, "R3 R1 x0&~x1 true");
        set_x(36'h3, "R1 complement literal blocks");
        set_x(36'h0, "R1 true literal missing");

        // R2: a mask written back to empty gives 0.
        wr(2'd0, 4*N_DED, lit_bit(0));
        set_x(36'h1, "R3 out4 private term");
        wr(2'd0, 4*N_DED, '0);
        expect_now("R2 empty mask evaluates 0");

        // R4 R5: pool 7 = x5, routed to outputs 0, 5 and 15.
        wr(2'd1, 7, lit_bit(10));
        wr(2'd2, 0, DW'(32'h80));
        wr(2'd2, 5, DW'(32'h80));
        wr(2'd2, 15, DW'(32'h80));
        set_x(36'h20, "R4 R5 shared pool term on three outputs");
        set_x(36'h00, "R5 shared term off");

        // R1: pool 8 selects both forms of x6; routed to output 9.
        wr(2'd1, 8, lit_bit(12) | lit_bit(13));
        wr(2'd2, 9, DW'(32'h100));
        set_x(36'h40, "R1 contradictory mask x6=1");
        set_x(36'h00, "R1 contradictory mask x6=0");

        // R8: out-of-range or reserved writes that would alias visibly.
        set_x(36'h21, "R8 baseline");
        wr(2'd2, 20, '1);
        expect_now("R8 OR-select addr 20 ignored");
        wr(2'd1, 40, lit_bit(0));
        expect_now("R8 pool addr 40 ignored");
        wr(2'd0, 90, lit_bit(0));
        expect_now("R8 private addr 90 ignored");
        wr(2'd3, 0, '1);
        expect_now("R8 reserved kind ignored");
        wr(2'd3, 9, lit_bit(0));
        expect_now("R8 reserved kind addr 9 ignored");

        // R6: output 12 gathers all 37 terms.
        do_reset();
        set_x('1, "R9 cleared after second reset");
        for (int k = 0; k < N_DED; k++) wr(2'd0, 12*N_DED + k, lit_bit(2*k));
        for (int j = 0; j < N_POOL - 1; j++) wr(2'd1, j, lit_bit(2*(j+5)));
        wr(2'd1, N_POOL - 1, lit_bit(0) | lit_bit(70));
        wr(2'd2, 12, DW'(32'hFFFF_FFFF));
        set_x('0, "R6 no term fires");
        for (int i = 0; i < N_IN; i++) set_x(N_IN'(1) << i, "R6 single term drives out12");
        set_x(36'h8_0000_0001, "R6 last pool term");

        // R11 R7: dropping the pool from output 12 leaves only private terms.
        set_x(36'h400, "R11 before deselect");
        wr(2'd2, 12, '0);
        expect_now("R11 R7 pool deselected");
        set_x(36'h4, "R3 private term still drives");
        wr(2'd2, 2, DW'(32'h20));
        set_x(36'h400, "R11 pool 5 moved to out2");

        // R10: pseudo-random patterns against the model.
        lfsr = 36'h9_ABCD_1234;
        for (int n = 0; n < 60; n++) begin
            lfsr = {lfsr[34:0], lfsr[35] ^ lfsr[24]};
            set_x(lfsr, "R10 R6 random pattern");
            expect_now("R10 held without writes");
        end

        do_reset();
        set_x(36'hF_FFFF_FFFF, "R9 final reset clears");

        repeat (2) @(posedge clk);
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", n_err, n_chk);
            $finish;
        end
    end
endmodule